// File: doc/BRIEF.md
# Scanline Timer with Horizontal Sync

The block is the time base for a raster video output. A free-running counter sets the length of every scanline. Each time it rolls over, it raises a one-clock line-start strobe, and the line renderer starts its work from that strobe. The same counter places the falling and rising edges of an active-low horizontal sync pulse at fixed absolute counts inside the line, not at the line boundary.

A second counter tracks which line of the frame is current. It raises a one-clock frame-start strobe whenever it wraps back to line 0. Neither counter depends on what the renderer downstream is doing: no input pauses or reloads them mid-frame. The one exception is the enable input, which freezes the whole block. Parameters set the line period, the number of lines, the two sync edge counts and the counter width.

Top module: `scanline_timer`

## Requirements
- R1: A synchronous reset sets `count` to 0, `lineNum` to 0 and `hsyncN` to 1, and drives `lineStart` and `frameStart` to 0.
- R2: On every clock edge with `en` high, `count` rises by exactly one, from 0 up to PERIOD-1 (default 1819, a 1820-clock line). From PERIOD-1 it returns to 0. `count` is 16 bits wide by default.
- R3: `lineStart` is 1 for exactly the one cycle in which `count` first shows 0 after a rollover. It is 0 at every other time, including right after reset.
- R4: `hsyncN` is 0 exactly while `count` is in the range SYNC_FALL to SYNC_RISE-1, and 1 otherwise. The defaults are SYNC_FALL = 0x68 and SYNC_RISE = 0xF0, which give a low pulse of 136 clocks on every line.
- R5: `lineNum` advances by one on each rollover of `count`, stays unchanged at all other times, and runs from 0 to LINES-1 (default 523, so a 524-line frame).
- R6: When `lineNum` wraps from LINES-1 to 0, `frameStart` is 1 for exactly that one cycle (the same cycle in which `lineStart` is 1). It is 0 at all other times.
- R7: When `en` is low at a clock edge, `count`, `lineNum` and `hsyncN` keep their values, and `lineStart` and `frameStart` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, the timer holds its state |
| count | output | CNT_W (16) | Current position within the scanline |
| lineStart | output | 1 | One-cycle strobe on the first count of a new line |
| hsyncN | output | 1 | Active-low horizontal sync |
| lineNum | output | $clog2(LINES) (10) | Current line within the frame |
| frameStart | output | 1 | One-cycle strobe when the line number wraps to 0 |

## Verification
The hardest case to reach is the frame wrap. With the default 1820 x 524 geometry it lies nearly a million clocks from reset. To get there, the bench runs a second instance with a short line (260 clocks, still holding the 104/240 sync edges) and a five-line frame, and sweeps it through several complete frames. The full-size instance is run through a few whole lines to check the real period and sync placement. Both instances get enable patterns with gaps, and one gap falls right on a rollover, so the hold behaviour is checked while a strobe is pending. Every output is compared each cycle with values derived by division and modulo from the number of enabled edges since reset.

// File: rtl/scanline_pkg.sv
`timescale 1ns/1ps
package scanline_pkg;
  // Strobes issued by the control to the datapath for one clock edge
  typedef struct packed {
    logic step;       // advance the scanline counter
    logic lineWrap;   // counter is at its last value and will roll over
    logic frameWrap;  // rollover on the last line of the frame
    logic syncFall;   // next count is the sync falling-edge position
    logic syncRise;   // next count is the sync rising-edge position
  } tmrCtl_t;
endpackage

// File: rtl/scanline_ctrl.sv
`timescale 1ns/1ps
module scanline_ctrl
  import scanline_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PERIOD    = 1820,
  parameter int LINES     = 524,
  parameter int SYNC_FALL = 104,
  parameter int SYNC_RISE = 240,
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LINE_W-1:0] lineNum,
  output tmrCtl_t           ctl
);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0]  PRE_FALL  = CNT_W'(SYNC_FALL - 1);
  localparam logic [CNT_W-1:0]  PRE_RISE  = CNT_W'(SYNC_RISE - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic atLast;
  logic onLastLine;

  assign atLast     = (cnt == LAST_CNT);
  assign onLastLine = (lineNum == LAST_LINE);

  always_comb begin
    ctl           = '0;
    ctl.step      = en;
    ctl.lineWrap  = en && atLast;
    ctl.frameWrap = en && atLast && onLastLine;
    ctl.syncFall  = en && (cnt == PRE_FALL);
    ctl.syncRise  = en && (cnt == PRE_RISE);
  end

  // The two sync edges and the rollover are at distinct counts, so at most one fires per edge
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.lineWrap, ctl.syncFall, ctl.syncRise})); // R4
  // A frame wrap is always also a line wrap
  AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    ctl.frameWrap |-> ctl.lineWrap); // R6
endmodule

// File: rtl/scanline_dp.sv
`timescale 1ns/1ps
module scanline_dp
  import scanline_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PERIOD    = 1820,
  parameter int LINES     = 524,
  parameter int SYNC_FALL = 104,
  parameter int SYNC_RISE = 240,
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  tmrCtl_t           ctl,
  output logic [CNT_W-1:0]  cnt,
  output logic [LINE_W-1:0] lineNum,
  output logic              syncN,
  output logic              lineStart,
  output logic              frameStart
);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0]  FALL_CNT  = CNT_W'(SYNC_FALL);
  localparam logic [CNT_W-1:0]  RISE_CNT  = CNT_W'(SYNC_RISE);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic started;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      lineNum    <= '0;
      syncN      <= 1'b1;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
      started    <= 1'b0;
    end else begin
      started    <= 1'b1;
      lineStart  <= ctl.lineWrap;
      frameStart <= ctl.frameWrap;
      if (ctl.step) begin
        cnt <= ctl.lineWrap ? '0 : cnt + 1'b1;
      end
      if (ctl.lineWrap) begin
        lineNum <= ctl.frameWrap ? '0 : lineNum + 1'b1;
      end
      if (ctl.syncFall) begin
        syncN <= 1'b0;
      end else if (ctl.syncRise) begin
        syncN <= 1'b1;
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    started && en && (cnt != LAST_CNT) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    started && en && (cnt == LAST_CNT) |=> cnt == '0); // R2
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_CNT); // R2
  AST_LINE_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    lineStart |-> cnt == '0); // R3
  AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    syncN == !((cnt >= FALL_CNT) && (cnt < RISE_CNT))); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    started && en && (cnt != LAST_CNT) |=> $stable(lineNum)); // R5
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    lineNum <= LAST_LINE); // R5
  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (lineNum == '0) && lineStart); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    started && !en |=> $stable(cnt) && $stable(lineNum) && $stable(syncN) && !lineStart); // R7
endmodule

// File: rtl/scanline_timer.sv
`timescale 1ns/1ps
module scanline_timer
  import scanline_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PERIOD    = 1820,
  parameter int LINES     = 524,
  parameter int SYNC_FALL = 104,
  parameter int SYNC_RISE = 240,
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [CNT_W-1:0]  count,
  output logic              lineStart,
  output logic              hsyncN,
  output logic [LINE_W-1:0] lineNum,
  output logic              frameStart
);
  tmrCtl_t ctl;

  scanline_ctrl #(
    .CNT_W(CNT_W), .PERIOD(PERIOD), .LINES(LINES),
    .SYNC_FALL(SYNC_FALL), .SYNC_RISE(SYNC_RISE)
  ) i_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .cnt(count), .lineNum(lineNum), .ctl(ctl)
  );

  scanline_dp #(
    .CNT_W(CNT_W), .PERIOD(PERIOD), .LINES(LINES),
    .SYNC_FALL(SYNC_FALL), .SYNC_RISE(SYNC_RISE)
  ) i_dp (
    .clk(clk), .rst(rst), .en(en), .ctl(ctl),
    .cnt(count), .lineNum(lineNum), .syncN(hsyncN),
    .lineStart(lineStart), .frameStart(frameStart)
  );
endmodule

// File: tb/test_scanline_timer.sv
`timescale 1ns/1ps
module test_scanline_timer;
  localparam int P_A = 1820, L_A = 524;
  localparam int P_B = 260,  L_B = 5;
  localparam int FALL = 104, RISE = 240;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enA = 1'b0, enB = 1'b0;
  logic [15:0] cntA, cntB;
  logic [9:0]  lineA;
  logic [2:0]  lineB;
  logic lsA, lsB, syA, syB, fsA, fsB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scanline_timer i_scanline_timer (
    .clk(clk), .rst(rst), .en(enA), .count(cntA), .lineStart(lsA),
    .hsyncN(syA), .lineNum(lineA), .frameStart(fsA));

  scanline_timer #(.PERIOD(P_B), .LINES(L_B), .SYNC_FALL(FALL), .SYNC_RISE(RISE)) i_small (
    .clk(clk), .rst(rst), .en(enB), .count(cntB), .lineStart(lsB),
    .hsyncN(syB), .lineNum(lineB), .frameStart(fsB));

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected values follow from t, the number of enabled edges since reset
  task automatic checkInst(input string name, input int p, input int l, input longint t,
                           input bit lastEn, input bit inReset,
                           input int aCnt, input int aLine, input int aSync,
                           input int aLs, input int aFs);
    int eCnt, eLine, eSync, eLs, eFs;
    string tCnt, tLine, tSync, tLs, tFs;
    eCnt  = int'(t % p);
    eLine = int'((t / p) % l);
    eSync = (eCnt >= FALL && eCnt < RISE) ? 0 : 1;
    eLs   = (lastEn && t > 0 && eCnt == 0) ? 1 : 0;
    eFs   = (eLs == 1 && eLine == 0) ? 1 : 0;
    tCnt = "R2"; tLine = "R5"; tSync = "R4"; tLs = "R3"; tFs = "R6";
    if (inReset) begin
      tCnt = "R1"; tLine = "R1"; tSync = "R1"; tLs = "R1"; tFs = "R1";
    end else if (!lastEn) begin
      tCnt = "R7"; tLine = "R7"; tSync = "R7"; tLs = "R7"; tFs = "R7";
    end
    cmp(tCnt,  {name, " count"},      aCnt,  eCnt);
    cmp(tLine, {name, " lineNum"},    aLine, eLine);
    cmp(tSync, {name, " hsyncN"},     aSync, eSync);
    cmp(tLs,   {name, " lineStart"},  aLs,   eLs);
    cmp(tFs,   {name, " frameStart"}, aFs,   eFs);
  endtask

  longint tA = 0, tB = 0;
  bit lastA = 0, lastB = 0;

  task automatic checkBoth(input bit inReset);
    checkInst("big", P_A, L_A, tA, lastA, inReset, int'(cntA), int'(lineA), int'(syA), int'(lsA), int'(fsA));
    checkInst("small", P_B, L_B, tB, lastB, inReset, int'(cntB), int'(lineB), int'(syB), int'(lsB), int'(fsB));
  endtask

  task automatic runPhase(input int n);
    for (int k = 0; k < n; k++) begin
      // gaps in enable; the small instance also pauses exactly at a rollover
      enA = !((k % 997) < 5);
      enB = ((k % 7) != 3) && !(tB % P_B == P_B - 1 && (k % 3) == 0 && k < 2000);
      @(negedge clk);
      if (enA) tA++;
      if (enB) tB++;
      lastA = enA;
      lastB = enB;
      checkBoth(1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkBoth(1'b1);                // R1 after power-up reset
    rst = 1'b0;
    runPhase(7000);                 // R2..R7 over several small frames and big lines
    rst = 1'b1; enA = 1'b1; enB = 1'b1;
    @(negedge clk);
    tA = 0; tB = 0; lastA = 0; lastB = 0;
    checkBoth(1'b1);                // R1 mid-run reset while enabled
    rst = 1'b0;
    runPhase(3000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule